// File: doc/BRIEF.md
# Multicart Outer Bank Controller

This block is the outer banking stage that sits next to an inner bank-switching mapper on a multi-game cartridge. The inner mapper appears here only as a set of bank-address inputs. The block watches CPU writes to the $6000-$7FFF window and latches a five-bit control word. From that word it drives the high PRG ROM address lines (A18..A17) and the high CHR ROM address lines. It also picks how PRG A13..A16 are formed, from one of four modes: plain inner banking, a fixed 32 KiB window, a mirrored 16 KiB window, and a mode in which CPU reads from ROM space return the board's two configuration jumpers instead of ROM data.

In the two fixed-window modes the block forces low the CPU A13/A14 lines that the inner mapper sees. A single inner bank register then covers the whole $8000-$FFFF range. Two static straps choose where CHR A17 and CHR A18 come from. Every output is combinational from the latched word, the straps and the current bus inputs. The only state is the control register, so no stream interface and no back-pressure rules apply: all pins are plain control and address lines.

Top module: `mc_outer_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the control word is zero. This gives PRG A18..A17 = 0 and inner banking mode, with CHR A17/A18 taken from the zero register bits when the straps are clear.
- R2: A write is latched on the clock edge only when cpu_addr[15:13] = 3'b011. Writes to any other address leave every output unchanged.
- R3: A write in the window is ignored when wram_en (the inner mapper's RAM-enable bit) is low.
- R4: The control word takes data bits 4..0, with bit 0 = PRG A17, bit 1 = PRG A18 (prg_addr[4] and prg_addr[5]), bits 3..2 = mode and bit 4 = alternate CHR A18.
- R5: Mode 0 (inner banking): prg_addr[3:0] = map_prg, and map_a13/map_a14 follow cpu_addr[13]/cpu_addr[14].
- R6: Mode 1 (32 KiB): prg_addr[1:0] = cpu_addr[14:13] and prg_addr[3:2] = map_prg[3:2].
- R7: Mode 3 (16 KiB): prg_addr[0] = cpu_addr[13] and prg_addr[3:1] = map_prg[3:1].
- R8: In modes 1 and 3, map_a13 and map_a14 are 0 for every CPU address. In modes 0 and 2 they follow the CPU address.
- R9: In mode 2, a read with cpu_addr[15] = 1 asserts rd_drive with rd_data = {6'b0, jumper} and holds rom_oe low. Outside mode 2, such a read asserts rom_oe with rd_drive low. Reads below $8000 assert neither.
- R10: With strap_chr17 = 0, chr_a17 is control bit 0. With strap_chr17 = 1, chr_a17 is map_chr17.
- R11: With strap_chr18 = 0, chr_a18 is control bit 1 (shared with PRG A18). With strap_chr18 = 1, chr_a18 is control bit 4.
- R12: Data bits 7..5 of a write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| wram_en | input | 1 | RAM-enable bit from the inner mapper |
| strap_chr17 | input | 1 | Static strap: CHR A17 source |
| strap_chr18 | input | 1 | Static strap: CHR A18 source |
| jumper | input | 2 | Configuration jumpers returned in mode 2 |
| map_prg | input | 4 | Inner mapper PRG A16..A13 |
| map_chr17 | input | 1 | Inner mapper CHR A17 |
| map_a13 | output | 1 | CPU A13 presented to the inner mapper |
| map_a14 | output | 1 | CPU A14 presented to the inner mapper |
| prg_addr | output | 6 | PRG ROM A18..A13 |
| chr_a17 | output | 1 | CHR ROM A17 |
| chr_a18 | output | 1 | CHR ROM A18 |
| rom_oe | output | 1 | PRG ROM output enable |
| rd_drive | output | 1 | Block drives rd_data onto the CPU bus |
| rd_data | output | 8 | Jumper readback data |

## Verification
The hardest cases to reach are the writes that must be ignored: a write in the right window while RAM is disabled, and writes just outside the window. Neither shows up unless the bench first loads a non-zero outer bank and then proves through prg_addr that it survived. Each rejection test therefore loads a known word first, sends the rejected write, and reads the outer bits back on the address pins before the next legal write. Mode 2 is reached by a legal write. The bench then issues reads on both sides of $8000 and checks that ROM enable and readback drive stay mutually exclusive.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int OUTER_W = 2;
  localparam int INNER_W = 4;
  localparam int CTRL_W  = OUTER_W + 3;
  localparam int PRG_W   = OUTER_W + INNER_W;

  typedef enum logic [1:0] {
    PM_INNER  = 2'd0,
    PM_FIX32  = 2'd1,
    PM_JUMPER = 2'd2,
    PM_MIR16  = 2'd3
  } prg_mode_e;

  typedef struct packed {
    logic                chr_alt;
    prg_mode_e           mode;
    logic [OUTER_W-1:0]  outer;
  } ctrl_t;
endpackage

// File: rtl/mc_ctrl_reg.sv
module mc_ctrl_reg
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 3,
  parameter logic [DEC_W-1:0] WIN_TAG = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              cpu_wr,
  input  logic              wram_en,
  output ctrl_t             q
);
  localparam int TAG_LO = ADDR_W - DEC_W;

  logic hit;
  logic unused_addr;

  assign hit         = (cpu_addr[ADDR_W-1:TAG_LO] == WIN_TAG);
  assign unused_addr = ^cpu_addr[TAG_LO-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cpu_wr && hit && wram_en) begin
      q <= ctrl_t'(wdata);
    end
  end
endmodule

// File: rtl/mc_prg_route.sv
module mc_prg_route
  import mc_pkg::*;
(
  input  ctrl_t              ctrl,
  input  logic [INNER_W-1:0] map_prg,
  input  logic               cpu_a13,
  input  logic               cpu_a14,
  output logic [PRG_W-1:0]   prg_addr,
  output logic               map_a13,
  output logic               map_a14
);
  logic [INNER_W-1:0] inner;
  logic               fixed_win;

  assign fixed_win = (ctrl.mode == PM_FIX32) || (ctrl.mode == PM_MIR16);
  assign map_a13   = fixed_win ? 1'b0 : cpu_a13;
  assign map_a14   = fixed_win ? 1'b0 : cpu_a14;

  for (genvar i = 0; i < INNER_W; i++) begin : g_bit
    always_comb begin
      inner[i] = map_prg[i];
      if (i == 0 && fixed_win)                 inner[i] = cpu_a13;
      if (i == 1 && ctrl.mode == PM_FIX32)     inner[i] = cpu_a14;
    end
  end

  assign prg_addr = {ctrl.outer, inner};
endmodule

// File: rtl/mc_chr_route.sv
module mc_chr_route
  import mc_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  strap_chr17,
  input  logic  strap_chr18,
  input  logic  map_chr17,
  output logic  chr_a17,
  output logic  chr_a18
);
  assign chr_a17 = strap_chr17 ? map_chr17    : ctrl.outer[0];
  assign chr_a18 = strap_chr18 ? ctrl.chr_alt : ctrl.outer[1];
endmodule

// File: rtl/mc_readback.sv
module mc_readback
  import mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ctrl_t             ctrl,
  input  logic              cpu_rd,
  input  logic              rom_space,
  input  logic [1:0]        jumper,
  output logic              rd_drive,
  output logic [DATA_W-1:0] rd_data,
  output logic              rom_oe
);
  logic rom_read;

  assign rom_read = cpu_rd && rom_space;
  assign rd_drive = rom_read && (ctrl.mode == PM_JUMPER);
  assign rom_oe   = rom_read && (ctrl.mode != PM_JUMPER);
  assign rd_data  = {{(DATA_W-2){1'b0}}, jumper};
endmodule

// File: rtl/mc_outer_bank.sv
module mc_outer_bank
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              wram_en,
  input  logic              strap_chr17,
  input  logic              strap_chr18,
  input  logic [1:0]        jumper,
  input  logic [3:0]        map_prg,
  input  logic              map_chr17,
  output logic              map_a13,
  output logic              map_a14,
  output logic [5:0]        prg_addr,
  output logic              chr_a17,
  output logic              chr_a18,
  output logic              rom_oe,
  output logic              rd_drive,
  output logic [7:0]        rd_data
);
  ctrl_t             ctrl;
  logic [CTRL_W-1:0] reg_bits;
  logic              unused_data;

  assign reg_bits    = ctrl;
  assign unused_data = ^cpu_wdata[DATA_W-1:CTRL_W];

  mc_ctrl_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .wdata    (cpu_wdata[CTRL_W-1:0]),
    .cpu_wr   (cpu_wr),
    .wram_en  (wram_en),
    .q        (ctrl)
  );

  mc_prg_route u_prg (
    .ctrl     (ctrl),
    .map_prg  (map_prg),
    .cpu_a13  (cpu_addr[13]),
    .cpu_a14  (cpu_addr[14]),
    .prg_addr (prg_addr),
    .map_a13  (map_a13),
    .map_a14  (map_a14)
  );

  mc_chr_route u_chr (
    .ctrl        (ctrl),
    .strap_chr17 (strap_chr17),
    .strap_chr18 (strap_chr18),
    .map_chr17   (map_chr17),
    .chr_a17     (chr_a17),
    .chr_a18     (chr_a18)
  );

  mc_readback #(.DATA_W(DATA_W)) u_rb (
    .ctrl      (ctrl),
    .cpu_rd    (cpu_rd),
    .rom_space (cpu_addr[ADDR_W-1]),
    .jumper    (jumper),
    .rd_drive  (rd_drive),
    .rd_data   (rd_data),
    .rom_oe    (rom_oe)
  );
endmodule

// File: rtl/mc_outer_bank_chk.sv
module mc_outer_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic        wram_en,
  input logic [4:0]  reg_bits,
  input logic        map_a13,
  input logic        map_a14,
  input logic        rom_oe,
  input logic        rd_drive
);
  // R2: writes outside the window leave the control word alone
  a_r2_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] != 3'b011) |=> $stable(reg_bits));

  // R3: RAM-enable low blocks the write
  a_r3_wram_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !wram_en) |=> $stable(reg_bits));

  // R4: an accepted write lands the low five data bits
  a_r4_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && wram_en && cpu_addr[15:13] == 3'b011) |=> (reg_bits == $past(cpu_wdata[4:0])));

  // R8: fixed-window modes hold the inner mapper's A13/A14 low
  a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_bits[2] |-> (!map_a13 && !map_a14));

  // R9: ROM enable and jumper drive never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_oe && rd_drive));
endmodule

bind mc_outer_bank mc_outer_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_wr    (cpu_wr),
  .wram_en   (wram_en),
  .reg_bits  (reg_bits),
  .map_a13   (map_a13),
  .map_a14   (map_a14),
  .rom_oe    (rom_oe),
  .rd_drive  (rd_drive)
);

// File: tb/mc_outer_bank_bench.sv
`timescale 1ns/1ps
module mc_outer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        wram_en = 1'b0;
  logic        strap_chr17 = 1'b0;
  logic        strap_chr18 = 1'b0;
  logic [1:0]  jumper = 2'b00;
  logic [3:0]  map_prg = '0;
  logic        map_chr17 = 1'b0;
  logic        map_a13, map_a14, chr_a17, chr_a18, rom_oe, rd_drive;
  logic [5:0]  prg_addr;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_outer_bank u_mc_outer_bank (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; wram_en = en; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; wram_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    map_prg = 4'b1001; cpu_addr = 16'hC000;
    #1;
    check("R1 prg during reset", {10'b0, prg_addr}, 16'h0009);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 prg after reset", {10'b0, prg_addr}, 16'h0009);
    check("R1 chr", {14'b0, chr_a18, chr_a17}, 16'h0000);
    check("R1 mapper a14/a13", {14'b0, map_a14, map_a13}, 16'h0002);
  endtask

  task automatic t_gate();
    wr(16'h6000, 8'h03, 1'b1);
    check("R4 outer bits loaded", {14'b0, prg_addr[5:4]}, 16'h0003);
    wr(16'h6000, 8'h00, 1'b0);
    check("R3 write ignored without wram_en", {14'b0, prg_addr[5:4]}, 16'h0003);
  endtask

  task automatic t_window();
    wr(16'h8000, 8'h00, 1'b1);
    check("R2 $8000 write ignored", {14'b0, prg_addr[5:4]}, 16'h0003);
    wr(16'h5FFF, 8'h00, 1'b1);
    check("R2 $5FFF write ignored", {14'b0, prg_addr[5:4]}, 16'h0003);
    wr(16'hE000, 8'h00, 1'b1);
    check("R2 $E000 write ignored", {14'b0, prg_addr[5:4]}, 16'h0003);
    wr(16'h7FFF, 8'h00, 1'b1);
    check("R2 $7FFF write taken", {14'b0, prg_addr[5:4]}, 16'h0000);
  endtask

  task automatic t_mode0();
    wr(16'h6000, 8'h02, 1'b1);
    map_prg = 4'b1010; cpu_addr = 16'hA000;
    #1;
    check("R5 inner passthrough", {10'b0, prg_addr}, 16'h002A);
    check("R5 mapper a14/a13 follow", {14'b0, map_a14, map_a13}, 16'h0001);
  endtask

  task automatic t_mode1();
    wr(16'h6000, 8'h05, 1'b1);
    map_prg = 4'b0110; cpu_addr = 16'hE000;
    #1;
    check("R6 32K window", {10'b0, prg_addr}, 16'h0017);
    check("R8 forced low mode1", {14'b0, map_a14, map_a13}, 16'h0000);
  endtask

  task automatic t_mode3();
    wr(16'h6000, 8'h0E, 1'b1);
    map_prg = 4'b0101; cpu_addr = 16'hA000;
    #1;
    check("R7 16K window", {10'b0, prg_addr}, 16'h0025);
    check("R8 forced low mode3", {14'b0, map_a14, map_a13}, 16'h0000);
  endtask

  task automatic t_mode2();
    wr(16'h6000, 8'h08, 1'b1);
    jumper = 2'b10; cpu_addr = 16'h8000; cpu_rd = 1'b1;
    #1;
    check("R9 readback drive/oe", {14'b0, rd_drive, rom_oe}, 16'h0002);
    check("R9 readback data", {8'b0, rd_data}, 16'h0002);
    cpu_addr = 16'h6000;
    #1;
    check("R9 no drive below $8000", {14'b0, rd_drive, rom_oe}, 16'h0000);
    cpu_addr = 16'hE000;
    #1;
    check("R8 not forced in mode2", {14'b0, map_a14, map_a13}, 16'h0003);
    cpu_rd = 1'b0;
    wr(16'h6000, 8'h00, 1'b1);
    cpu_addr = 16'h9000; cpu_rd = 1'b1;
    #1;
    check("R9 mode0 rom read", {14'b0, rd_drive, rom_oe}, 16'h0001);
    cpu_rd = 1'b0;
  endtask

  task automatic t_chr();
    wr(16'h6000, 8'h13, 1'b1);
    strap_chr17 = 1'b0; strap_chr18 = 1'b0; map_chr17 = 1'b0;
    #1;
    check("R10 chr17 from register", {15'b0, chr_a17}, 16'h0001);
    strap_chr17 = 1'b1;
    #1;
    check("R10 chr17 from mapper", {15'b0, chr_a17}, 16'h0000);
    check("R11 chr18 from bit1", {15'b0, chr_a18}, 16'h0001);
    wr(16'h6000, 8'h11, 1'b1);
    #1;
    check("R11 chr18 shared bit1 clear", {15'b0, chr_a18}, 16'h0000);
    strap_chr18 = 1'b1;
    #1;
    check("R11 chr18 from bit4", {15'b0, chr_a18}, 16'h0001);
    wr(16'h6000, 8'h02, 1'b1);
    #1;
    check("R11 chr18 bit4 clear", {15'b0, chr_a18}, 16'h0000);
    strap_chr17 = 1'b0; strap_chr18 = 1'b0;
  endtask

  task automatic t_upper();
    wr(16'h6000, 8'hE3, 1'b1);
    map_prg = 4'b0000; cpu_addr = 16'hE000;
    #1;
    check("R12 upper bits ignored prg", {10'b0, prg_addr}, 16'h0030);
    check("R12 upper bits ignored mode", {14'b0, map_a14, map_a13}, 16'h0003);
    strap_chr18 = 1'b1;
    #1;
    check("R12 bit5+ not chr_alt", {15'b0, chr_a18}, 16'h0000);
    strap_chr18 = 1'b0;
  endtask

  initial begin
    t_reset();
    t_gate();
    t_window();
    t_mode0();
    t_mode1();
    t_mode3();
    t_mode2();
    t_chr();
    t_upper();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule